// File: doc/BRIEF.md
# Burst-Mode Handshake Controller

This block is a clocked controller that follows a fixed burst-mode state machine. It has three level inputs (A, B, C), two level outputs (Y, Z) and six states. In each state it waits for an input burst: a set of inputs that must all reach their required levels. The inputs of a burst may arrive in any order and over any number of cycles. When the last one arrives, the controller applies the matching output burst in a single step and moves to the next state. An output burst may be empty.

The inputs are assumed to be synchronized already. The controller registers them once. It then measures how far each input has moved from the levels it had when the current state was entered. Any change that fits no enabled burst raises an error flag and holds the state.

Top module: `bm_ctrl`

## Requirements
- R1: After reset the outputs are Y=0 and Z=1, the error flag is 0, and the controller is in state 0, whose entry input levels are A=B=C=0.
- R2: In state 0, once both A and C have risen (in either order), Z falls and Y stays 0. The controller moves to state 1.
- R3: In state 0, once both A and B have risen (in either order), Y rises and Z falls together. The controller moves to state 3.
- R4: While only part of a burst has arrived, both outputs and the error flag stay unchanged.
- R5: In state 1, C falling raises Z (YZ=01, state 2). In state 2, C rising then raises Y (YZ=11, state 4).
- R6: In state 3, once B has fallen and C has risen (in either order), Z rises (YZ=11, state 4).
- R7: In state 4, C falling is an empty output burst: YZ stays 11 and the state becomes 5. In state 5, A falling drops Y (YZ=01) and returns to state 0.
- R8: An input change that fits no enabled burst sets the error flag and holds the state and outputs. The flag clears once the stray change is undone.
- R9: Outputs and the error flag update on the second rising clock edge after the completing input is applied. They do not update on the first edge, which only samples the inputs.
- R10: While the sampled inputs equal the current state's entry levels, the state does not change.
- R11: For any sequence of input levels, Y, Z and the error flag match the burst table given in R1 to R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_a | input | 1 | Synchronized input A |
| in_b | input | 1 | Synchronized input B |
| in_c | input | 1 | Synchronized input C |
| out_y | output | 1 | Output Y |
| out_z | output | 1 | Output Z |
| err | output | 1 | Set while the sampled inputs fit no enabled burst |

## Verification
Most states drive a distinct YZ pair, so a wrong state usually shows at the outputs on the same edge it is entered. The exceptions are state pairs 0/2 and 4/5, which share output values. A mix-up between those shows only when the next input arrives: that input then either raises the error flag or leaves the outputs stuck. The bench therefore keeps a reference model running under random walks toward each state's bursts. It compares outputs and the flag every cycle, so such a divergence surfaces within one burst of its cause.

// File: rtl/bm_pkg.sv
`timescale 1ns/1ps
package bm_pkg;
  localparam int NIN      = 3;   // input order in vectors: [2]=A [1]=B [0]=C
  localparam int NOUT     = 2;   // output order: [1]=Y [0]=Z
  localparam int NSTATE   = 6;
  localparam int MAX_ARCS = 2;
  localparam int SW       = $clog2(NSTATE);

  typedef enum logic [SW-1:0] {
    ST_IDLE  = 3'd0,
    ST_AC    = 3'd1,
    ST_AC_LO = 3'd2,
    ST_AB    = 3'd3,
    ST_JOIN  = 3'd4,
    ST_TAIL  = 3'd5
  } bm_state_e;

  typedef struct packed {
    logic                valid;
    logic [NIN-1:0]      mask;
    bm_state_e           dst;
  } arc_t;

  // Input levels on entry to each state.
  function automatic logic [NIN-1:0] entry_lvl(bm_state_e s);
    case (s)
      ST_AC, ST_JOIN:   return 3'b101;
      ST_AC_LO, ST_TAIL: return 3'b100;
      ST_AB:            return 3'b110;
      default:          return 3'b000;
    endcase
  endfunction

  // Output levels held in each state.
  function automatic logic [NOUT-1:0] out_lvl(bm_state_e s);
    case (s)
      ST_AC:            return 2'b00;
      ST_AB:            return 2'b10;
      ST_JOIN, ST_TAIL: return 2'b11;
      default:          return 2'b01;
    endcase
  endfunction

  // Enabled bursts: which inputs must toggle, and where they lead.
  function automatic arc_t arc_of(bm_state_e s, int unsigned k);
    arc_t r;
    r.valid = 1'b0;
    r.mask  = '0;
    r.dst   = ST_IDLE;
    case (s)
      ST_IDLE: begin
        r.valid = 1'b1;
        if (k == 0) begin r.mask = 3'b101; r.dst = ST_AC; end
        else        begin r.mask = 3'b110; r.dst = ST_AB; end
      end
      ST_AC:    if (k == 0) begin r.valid = 1'b1; r.mask = 3'b001; r.dst = ST_AC_LO; end
      ST_AC_LO: if (k == 0) begin r.valid = 1'b1; r.mask = 3'b001; r.dst = ST_JOIN;  end
      ST_AB:    if (k == 0) begin r.valid = 1'b1; r.mask = 3'b011; r.dst = ST_JOIN;  end
      ST_JOIN:  if (k == 0) begin r.valid = 1'b1; r.mask = 3'b001; r.dst = ST_TAIL;  end
      ST_TAIL:  if (k == 0) begin r.valid = 1'b1; r.mask = 3'b100; r.dst = ST_IDLE;  end
      default: ;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/bm_in_sampler.sv
`timescale 1ns/1ps
module bm_in_sampler #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] lvl_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_i;
  end
endmodule

// File: rtl/bm_burst_match.sv
`timescale 1ns/1ps
module bm_burst_match
  import bm_pkg::*;
(
  input  bm_state_e      cur,
  input  logic [NIN-1:0] lvl,
  output logic [NIN-1:0] arr_mask,
  output logic           fire,
  output logic           bad,
  output bm_state_e      nxt
);
  logic [MAX_ARCS-1:0] fits;
  logic [MAX_ARCS-1:0] hit;
  bm_state_e           dst [MAX_ARCS];

  // Arrival mask: inputs that moved since the state was entered.
  assign arr_mask = lvl ^ entry_lvl(cur);

  for (genvar k = 0; k < MAX_ARCS; k++) begin : g_arc
    arc_t arc_k;
    assign arc_k   = arc_of(cur, k);
    assign fits[k] = arc_k.valid && ((arr_mask & ~arc_k.mask) == '0);
    assign hit[k]  = fits[k] && (arr_mask == arc_k.mask);
    assign dst[k]  = arc_k.dst;
  end

  always_comb begin
    fire = |hit;
    nxt  = cur;
    for (int k = MAX_ARCS - 1; k >= 0; k--) begin
      if (hit[k]) nxt = dst[k];
    end
    bad = (arr_mask != '0) && !(|fits);
  end
endmodule

// File: rtl/bm_state_reg.sv
`timescale 1ns/1ps
module bm_state_reg
  import bm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      fire,
  input  logic      bad,
  input  bm_state_e nxt,
  output bm_state_e state_q,
  output logic      err_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
    end else begin
      if (fire) state_q <= nxt;
      err_q <= bad;
    end
  end
endmodule

// File: rtl/bm_ctrl.sv
`timescale 1ns/1ps
module bm_ctrl
  import bm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_a,
  input  logic in_b,
  input  logic in_c,
  output logic out_y,
  output logic out_z,
  output logic err
);
  logic [NIN-1:0]  lvl_q;
  logic [NIN-1:0]  arr_mask;
  logic [NOUT-1:0] yz;
  logic            fire_w;
  logic            bad_w;
  logic            err_q;
  bm_state_e       nxt_w;
  bm_state_e       state_q;

  bm_in_sampler #(.W(NIN)) u_smp (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl_i ({in_a, in_b, in_c}),
    .lvl_q (lvl_q)
  );

  bm_burst_match u_match (
    .cur      (state_q),
    .lvl      (lvl_q),
    .arr_mask (arr_mask),
    .fire     (fire_w),
    .bad      (bad_w),
    .nxt      (nxt_w)
  );

  bm_state_reg u_st (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (fire_w),
    .bad     (bad_w),
    .nxt     (nxt_w),
    .state_q (state_q),
    .err_q   (err_q)
  );

  assign yz    = out_lvl(state_q);
  assign out_y = yz[1];
  assign out_z = yz[0];
  assign err   = err_q;
endmodule

// File: rtl/bm_ctrl_chk.sv
`timescale 1ns/1ps
module bm_ctrl_chk
  import bm_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input bm_state_e       state_q,
  input logic [NIN-1:0]  arr_mask,
  input logic            fire_w,
  input logic            bad_w,
  input logic            err_q
);
  a_r4_fire_excludes_bad: assert property (@(posedge clk) disable iff (!rst_n)
    !(fire_w && bad_w));

  a_r8_bad_sets_err: assert property (@(posedge clk) disable iff (!rst_n)
    bad_w |=> err_q);

  a_r8_err_holds_state: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $stable(state_q));

  a_r9_move_needs_fire: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(state_q) |-> $past(fire_w));

  a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_mask == '0) |=> $stable(state_q));

  a_r11_state_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(state_q) < NSTATE);
endmodule

bind bm_ctrl bm_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .state_q  (state_q),
  .arr_mask (arr_mask),
  .fire_w   (fire_w),
  .bad_w    (bad_w),
  .err_q    (err_q)
);

// File: tb/bm_ctrl_test.sv
`timescale 1ns/1ps
module bm_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] drv = 3'b000;   // [2]=A [1]=B [0]=C
  logic       out_y, out_z, err;
  int         checks = 0;
  int         fails  = 0;
  bit         mon_on = 1'b0;

  always #2.5 clk = ~clk;

  bm_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .in_a(drv[2]), .in_b(drv[1]), .in_c(drv[0]),
    .out_y(out_y), .out_z(out_z), .err(err)
  );

  // Reference model: legal levels and completing targets per state.
  function automatic int m_next(int s, logic [2:0] v, output logic e);
    e = 1'b0;
    case (s)
      0: begin
        if (v == 3'b101) return 1;
        if (v == 3'b110) return 3;
        e = !(v inside {3'b000, 3'b001, 3'b100, 3'b010});
        return 0;
      end
      1: begin if (v == 3'b100) return 2; e = (v != 3'b101); return 1; end
      2: begin if (v == 3'b101) return 4; e = (v != 3'b100); return 2; end
      3: begin
        if (v == 3'b101) return 4;
        e = !(v inside {3'b110, 3'b100, 3'b111});
        return 3;
      end
      4: begin if (v == 3'b100) return 5; e = (v != 3'b101); return 4; end
      default: begin if (v == 3'b000) return 0; e = (v != 3'b100); return 5; end
    endcase
  endfunction

  function automatic logic [1:0] m_yz(int s);
    case (s)
      1: return 2'b00;
      3: return 2'b10;
      4, 5: return 2'b11;
      default: return 2'b01;
    endcase
  endfunction

  function automatic logic [2:0] m_goal(int s, bit alt);
    case (s)
      0: return alt ? 3'b110 : 3'b101;
      1: return 3'b100;
      2, 3: return 3'b101;
      4: return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  int         ms = 0;
  logic [2:0] mq = 3'b000;
  logic       merr = 1'b0;

  always @(posedge clk) begin
    logic e;
    int   n;
    if (!rst_n) begin
      ms <= 0; mq <= 3'b000; merr <= 1'b0;
    end else begin
      n = m_next(ms, mq, e);
      ms <= n; merr <= e; mq <= drv;
    end
  end

  task automatic chk(string tag, logic [1:0] exp_yz, logic exp_err);
    checks++;
    if ({out_y, out_z} !== exp_yz || err !== exp_err) begin
      fails++;
      $display("FAIL %s: yz=%b err=%b expected yz=%b err=%b",
               tag, {out_y, out_z}, err, exp_yz, exp_err);
    end
  endtask

  always @(negedge clk) if (mon_on) chk("R11 model", m_yz(ms), merr);

  task automatic put(logic [2:0] v);
    @(negedge clk); drv = v;
  endtask

  task automatic step;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R11 watchdog: cycles=150000 expected earlier finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) step();
    chk("R1 in reset", 2'b01, 1'b0);
    rst_n = 1'b1;
    step(); mon_on = 1'b1;
    chk("R1 after reset", 2'b01, 1'b0);

    // R2 with C first, R4 partial, R9 latency
    put(3'b001); step(); step(); chk("R4 partial C", 2'b01, 1'b0);
    put(3'b101); step(); chk("R9 first edge only samples", 2'b01, 1'b0);
    step(); chk("R2 A+C+ Z falls", 2'b00, 1'b0);
    // R5
    put(3'b100); step(); step(); chk("R5 C- Z rises", 2'b01, 1'b0);
    put(3'b101); step(); step(); chk("R5 C+ Y rises", 2'b11, 1'b0);
    // R7 empty burst then return
    put(3'b100); step(); step(); chk("R7 empty burst holds", 2'b11, 1'b0);
    put(3'b000); step(); step(); chk("R7 A- Y falls", 2'b01, 1'b0);
    // R10 hold
    repeat (4) step(); chk("R10 no change holds", 2'b01, 1'b0);
    // R3 with B first
    put(3'b010); step(); step(); chk("R4 partial B", 2'b01, 1'b0);
    put(3'b110); step(); chk("R9 sample edge", 2'b01, 1'b0);
    step(); chk("R3 A+B+ YZ=10", 2'b10, 1'b0);
    // R6 with C first
    put(3'b111); step(); step(); chk("R4 partial C in state 3", 2'b10, 1'b0);
    put(3'b101); step(); step(); chk("R6 B-C+ Z rises", 2'b11, 1'b0);
    // R8 stray B in state 4
    put(3'b111); step(); step(); chk("R8 stray B flags", 2'b11, 1'b1);
    put(3'b101); step(); step(); chk("R8 flag clears", 2'b11, 1'b0);
    put(3'b100); step(); step(); chk("R7 state 5 reached", 2'b11, 1'b0);
    put(3'b000); step(); step(); chk("R7 back to state 0", 2'b01, 1'b0);
    // R8 mixed bursts in state 0
    put(3'b011); step(); step(); chk("R8 B and C mixed", 2'b01, 1'b1);
    put(3'b000); step(); step(); chk("R8 cleared in state 0", 2'b01, 1'b0);

    // R11 random walk
    for (int i = 0; i < 4000; i++) begin
      int r;
      @(negedge clk);
      r = $urandom_range(0, 99);
      if (r >= 30 && r < 85) begin
        logic [2:0] d;
        d = drv ^ m_goal(ms, bit'($urandom_range(0, 1)));
        for (int t = 0; t < 4; t++) begin
          int b;
          b = $urandom_range(0, 2);
          if (d[b]) begin drv[b] = ~drv[b]; break; end
        end
      end else if (r >= 85) begin
        int b;
        b = $urandom_range(0, 2);
        drv[b] = ~drv[b];
      end
    end
    repeat (3) step();
    mon_on = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule